// File: doc/BRIEF.md
# Gate-Driver Configuration Sequencer

This block configures an external three-phase motor gate-driver chip on its own after power-up. Once reset has been released and the enable input is high, it turns on the chip's enable pin and writes five 16-bit configuration words in a fixed order. It uses a write-only SPI master made of chip select, serial clock and data out. Every word goes out in its own chip-select frame. When the last frame has closed, a ready flag rises and stays high.

The block also handles the chip's run-time controls. A stop request with the coast option selected pulls the chip enable low. A stop with the brake option selected leaves the enable high, because braking is the bridge logic's job. The chip's active-low fault pin latches three per-phase fault flags. A clear pulse drops those flags and starts the whole configuration run again from the first word, with ready low.

The serial clock is the system clock divided by `CLK_DIV`. The third and fifth words are the parameters `WORD_C` and `WORD_E`.

Top module: `gdrv_cfg_seq`

## Requirements
- R1: After reset, with `en` high, exactly five frames are sent. No further frame starts until `clr_fault` is pulsed.
- R2: Each frame holds exactly 16 falling serial-clock edges between the fall of `spi_cs_n` and its rise.
- R3: `spi_sck` is low at every falling edge and every rising edge of `spi_cs_n`.
- R4: Bits go out MSB first. `spi_mosi` changes only together with a rising serial-clock edge or a chip-select fall, so it is stable at every falling serial-clock edge, where the receiver samples it.
- R5: The words are sent in this order: 0x2820, 0x3842, `WORD_C`, 0x596D, `WORD_E`.
- R6: Inside a frame, successive rising serial-clock edges are `CLK_DIV` system clocks apart. Between two frames, and from reset to the first frame, `spi_cs_n` stays high for at least `2*CLK_DIV` system clocks.
- R7: `cfg_ready` is low from reset until the fifth frame's chip select has risen. After that it stays high until `clr_fault`, and it is never high while `spi_cs_n` is low.
- R8: `gate_en` equals `en AND NOT (stop AND coast_sel)`, registered, one clock after the inputs. `coast_sel`=1 means coast and `coast_sel`=0 means brake.
- R9: `fault_n` low for one clock or more sets `flt_a`, `flt_b` and `flt_c` within four clocks. They stay set after `fault_n` returns high.
- R10: A `clr_fault` pulse clears the flags (if `fault_n` is high at that time), drops `cfg_ready`, raises `spi_cs_n` on the next clock even in mid-frame, and restarts the run from the first word.
- R11: While `en` has stayed low since reset, `gate_en` is low and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Start configuration and enable the driver chip |
| fault_n | input | 1 | Active-low fault pin of the driver chip |
| stop | input | 1 | Stop request |
| coast_sel | input | 1 | Stop action: 1 coast, 0 brake |
| clr_fault | input | 1 | Pulse: clear fault flags and restart configuration |
| gate_en | output | 1 | Driver chip enable |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI data to the chip |
| cfg_ready | output | 1 | All configuration words written |
| flt_a | output | 1 | Phase A fault flag |
| flt_b | output | 1 | Phase B fault flag |
| flt_c | output | 1 | Phase C fault flag |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a frame. The engine must then cut the frame short with the serial clock low, observe the full inter-frame gap, and send the whole five-word list again. The bench waits until chip select is low and several bits have gone out before it pulses the clear input, and it marks that one truncated frame as expected. A clear while the fault pin is still held low is also driven, to show that the pending fault wins over the clear. A randomised stretch of stop, coast and enable patterns covers the enable logic.

// File: rtl/gdrv_cfg_pkg.sv
package gdrv_cfg_pkg;
  localparam int CFG_W = 16;
  localparam int CFG_N = 5;
  localparam int IDX_W = $clog2(CFG_N);

  typedef logic [CFG_W-1:0] cfg_word_t;
  typedef logic [IDX_W-1:0] cfg_idx_t;

  typedef enum logic [1:0] {SQ_WAIT, SQ_RUN, SQ_DONE} seq_state_t;
  typedef enum logic [2:0] {TX_IDLE, TX_LEAD, TX_HI, TX_LO, TX_GAP} tx_state_t;

  // Fixed write order; two slots come from parameters of the top.
  function automatic cfg_word_t cfg_word(input cfg_idx_t idx,
                                         input cfg_word_t w_c,
                                         input cfg_word_t w_e);
    case (idx)
      cfg_idx_t'(0): return 16'h2820;
      cfg_idx_t'(1): return 16'h3842;
      cfg_idx_t'(2): return w_c;
      cfg_idx_t'(3): return 16'h596D;
      default:       return w_e;
    endcase
  endfunction
endpackage

// File: rtl/gdrv_spi_tx.sv
module gdrv_spi_tx
  import gdrv_cfg_pkg::*;
#(
  parameter int W       = 16,
  parameter int CLK_DIV = 4,
  parameter int GAP_SCK = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         frame_end,
  output logic         cs_n,
  output logic         sck,
  output logic         mosi
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int GAP_CLKS = GAP_SCK * CLK_DIV;
  localparam int CNT_W    = $clog2(GAP_CLKS + 1);
  localparam int BIT_W    = $clog2(W);

  tx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bits_left;
  logic [W-1:0]     shreg;
  logic             half_end, gap_end;

  assign busy     = (state != TX_IDLE);
  assign half_end = (cnt == CNT_W'(HALF - 1));
  assign gap_end  = (cnt == CNT_W'(GAP_CLKS - 1));

  // Reset lands in the gap state so chip select is high long enough before frame one.
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_GAP;
      cnt       <= '0;
      bits_left <= '0;
      shreg     <= '0;
      cs_n      <= 1'b1;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (abort) begin
        state <= TX_GAP;
        cnt   <= '0;
        cs_n  <= 1'b1;
        sck   <= 1'b0;
      end else begin
        case (state)
          TX_IDLE: if (start) begin
            cs_n      <= 1'b0;
            mosi      <= word[W-1];
            shreg     <= {word[W-2:0], 1'b0};
            bits_left <= BIT_W'(W - 1);
            cnt       <= '0;
            state     <= TX_LEAD;
          end
          TX_LEAD: if (half_end) begin
            cnt   <= '0;
            sck   <= 1'b1;
            state <= TX_HI;
          end else cnt <= cnt + 1'b1;
          TX_HI: if (half_end) begin
            cnt   <= '0;
            sck   <= 1'b0;
            state <= TX_LO;
          end else cnt <= cnt + 1'b1;
          TX_LO: if (half_end) begin
            cnt <= '0;
            if (bits_left == '0) begin
              cs_n      <= 1'b1;
              frame_end <= 1'b1;
              state     <= TX_GAP;
            end else begin
              bits_left <= bits_left - 1'b1;
              mosi      <= shreg[W-1];
              shreg     <= {shreg[W-2:0], 1'b0};
              sck       <= 1'b1;
              state     <= TX_HI;
            end
          end else cnt <= cnt + 1'b1;
          TX_GAP: if (gap_end) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else cnt <= cnt + 1'b1;
          default: state <= TX_GAP;
        endcase
      end
    end
  end

  // Length of the current chip-select high stretch, saturating.
  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)                          hi_run <= '0;
    else if (!cs_n)                   hi_run <= '0;
    else if (hi_run != {CNT_W{1'b1}}) hi_run <= hi_run + 1'b1;
  end

  p_sck_low_cs_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sck);
  p_sck_low_cs_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !sck);
  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |-> $stable(mosi));
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_run >= CNT_W'(GAP_CLKS)));
endmodule

// File: rtl/gdrv_fault_latch.sv
module gdrv_fault_latch #(
  parameter int PHASES = 3,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_n,
  input  logic              clr,
  output logic [PHASES-1:0] flags
);
  logic [SYNC-1:0] sync_q;
  logic            active;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], fault_n};
  end

  assign active = !sync_q[SYNC-1];

  // A pending fault wins over a clear in the same cycle.
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst)         flags[p] <= 1'b0;
      else if (active) flags[p] <= 1'b1;
      else if (clr)    flags[p] <= 1'b0;
    end
  end

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !clr) |=> flags[0]);
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !active) |=> (flags == '0));
endmodule

// File: rtl/gdrv_cfg_seq.sv
module gdrv_cfg_seq
  import gdrv_cfg_pkg::*;
#(
  parameter int        CLK_DIV = 4,
  parameter int        GAP_SCK = 2,
  parameter cfg_word_t WORD_C  = 16'h4C3F,
  parameter cfg_word_t WORD_E  = 16'h6E01
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fault_n,
  input  logic stop,
  input  logic coast_sel,
  input  logic clr_fault,
  output logic gate_en,
  output logic spi_cs_n,
  output logic spi_sck,
  output logic spi_mosi,
  output logic cfg_ready,
  output logic flt_a,
  output logic flt_b,
  output logic flt_c
);
  seq_state_t sq;
  cfg_idx_t   idx;
  logic       tx_start, tx_busy, tx_frame_end;
  cfg_word_t  tx_word;
  logic [2:0] flags;

  assign tx_word  = cfg_word(idx, WORD_C, WORD_E);
  assign tx_start = (sq == SQ_RUN) && !tx_busy && !clr_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq        <= SQ_WAIT;
      idx       <= '0;
      cfg_ready <= 1'b0;
      gate_en   <= 1'b0;
    end else begin
      gate_en <= en && !(stop && coast_sel);
      if (clr_fault) begin
        sq        <= SQ_WAIT;
        idx       <= '0;
        cfg_ready <= 1'b0;
      end else begin
        case (sq)
          SQ_WAIT: if (en) sq <= SQ_RUN;
          SQ_RUN: if (tx_frame_end) begin
            if (idx == cfg_idx_t'(CFG_N - 1)) begin
              sq        <= SQ_DONE;
              cfg_ready <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  gdrv_spi_tx #(.W(CFG_W), .CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .start     (tx_start),
    .abort     (clr_fault),
    .word      (tx_word),
    .busy      (tx_busy),
    .frame_end (tx_frame_end),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi)
  );

  gdrv_fault_latch #(.PHASES(3), .SYNC(2)) u_flt (
    .clk     (clk),
    .rst     (rst),
    .fault_n (fault_n),
    .clr     (clr_fault),
    .flags   (flags)
  );

  assign flt_a = flags[0];
  assign flt_b = flags[1];
  assign flt_c = flags[2];

  p_idx_bound_r1: assert property (@(posedge clk) disable iff (rst)
    idx <= cfg_idx_t'(CFG_N - 1));
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_ready && !clr_fault) |=> cfg_ready);
  p_ready_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |-> spi_cs_n);
  p_coast_off_r8: assert property (@(posedge clk) disable iff (rst)
    (stop && coast_sel) |=> !gate_en);
  p_clear_drop_r10: assert property (@(posedge clk) disable iff (rst)
    clr_fault |=> (!cfg_ready && spi_cs_n));
endmodule

// File: tb/gdrv_cfg_seq_tb_top.sv
module gdrv_cfg_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int MIN_GAP    = 2 * DIV;
  localparam logic [15:0] TB_WC = 16'hA1B5;
  localparam logic [15:0] TB_WE = 16'h0F96;
  localparam int WDOG       = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, fault_n = 1'b1, stop = 1'b0, coast_sel = 1'b0, clr_fault = 1'b0;
  logic gate_en, spi_cs_n, spi_sck, spi_mosi, cfg_ready, flt_a, flt_b, flt_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  gdrv_cfg_seq #(.CLK_DIV(DIV), .GAP_SCK(2), .WORD_C(TB_WC), .WORD_E(TB_WE)) dut_i (
    .clk(clk), .rst(rst), .en(en), .fault_n(fault_n), .stop(stop),
    .coast_sel(coast_sel), .clr_fault(clr_fault), .gate_en(gate_en),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .cfg_ready(cfg_ready), .flt_a(flt_a), .flt_b(flt_b), .flt_c(flt_c)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int frame_cnt = 0;
  bit abort_pend = 1'b0;

  function automatic logic [15:0] exp_word(input int i);
    case (i)
      0: return 16'h2820;
      1: return 16'h3842;
      2: return TB_WC;
      3: return 16'h596D;
      default: return TB_WE;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc >= WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  // SPI frame monitor, sampling between clock edges
  logic cs_prev = 1'b1, sck_prev = 1'b0;
  logic [15:0] rx_sh = '0;
  int rx_bits = 0, last_rise = -1, gap = 0;
  bit per_bad = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_prev && !spi_cs_n) begin
        chk(spi_sck == 1'b0, "R3", "sck at cs fall", spi_sck, 0);
        chk(gap >= MIN_GAP, "R6", "cs high gap", gap, MIN_GAP);
        rx_bits = 0; rx_sh = '0; last_rise = -1; per_bad = 1'b0;
      end
      if (!spi_cs_n) begin
        if (spi_sck && !sck_prev) begin
          if (last_rise >= 0 && (cyc - last_rise) != DIV) per_bad = 1'b1;
          last_rise = cyc;
        end
        if (!spi_sck && sck_prev) begin
          rx_sh = {rx_sh[14:0], spi_mosi};
          rx_bits++;
        end
      end
      if (!cs_prev && spi_cs_n) begin
        chk(spi_sck == 1'b0, "R3", "sck at cs rise", spi_sck, 0);
        if (abort_pend) abort_pend = 1'b0;
        else begin
          chk(rx_bits == 16, "R2", "bits per frame", rx_bits, 16);
          chk(rx_sh == exp_word(frame_cnt), "R5", "word MSB first (R4)", rx_sh, exp_word(frame_cnt));
          chk(!per_bad, "R6", "sck period", per_bad, 0);
          chk(frame_cnt < 5, "R1", "frames in run", frame_cnt + 1, 5);
          frame_cnt++;
        end
      end
      gap = spi_cs_n ? gap + 1 : 0;
    end
    cs_prev  = spi_cs_n;
    sck_prev = spi_sck;
  end

  task automatic wait_ready();
    for (int k = 0; k < 3000 && !cfg_ready; k++) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R3", "reset bus idle", {spi_cs_n, spi_sck}, 2'b10);
    chk(cfg_ready == 1'b0, "R7", "reset ready", cfg_ready, 0);
    chk({flt_a, flt_b, flt_c} == 3'b000, "R9", "reset flags", {flt_a, flt_b, flt_c}, 0);
    rst = 1'b0;

    // Stay disabled for a random stretch
    repeat (5 + ($urandom % 40)) @(negedge clk);
    chk(gate_en == 1'b0, "R11", "enable before en", gate_en, 0);
    chk(frame_cnt == 0, "R11", "frames before en", frame_cnt, 0);

    en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(gate_en == 1'b1, "R8", "enable after en", gate_en, 1);
    wait_ready();
    chk(cfg_ready == 1'b1, "R7", "ready after run", cfg_ready, 1);
    chk(frame_cnt == 5, "R1", "frames at ready", frame_cnt, 5);
    repeat (120) @(negedge clk);
    chk(frame_cnt == 5, "R1", "no extra frame", frame_cnt, 5);
    chk(cfg_ready == 1'b1, "R7", "ready sticky", cfg_ready, 1);

    // Random enable / stop / coast patterns
    for (int it = 0; it < 24; it++) begin
      en = $urandom % 2; stop = $urandom % 2; coast_sel = $urandom % 2;
      @(negedge clk);
      chk(gate_en == (en && !(stop && coast_sel)), "R8", "gate enable",
          gate_en, en && !(stop && coast_sel));
    end
    en = 1'b1; stop = 1'b1; coast_sel = 1'b0;
    @(negedge clk);
    chk(gate_en == 1'b1, "R8", "brake keeps enable", gate_en, 1);
    stop = 1'b0;
    chk(cfg_ready == 1'b1 && frame_cnt == 5, "R1", "control inputs start no frame", frame_cnt, 5);

    // Fault pulse of random length
    fault_n = 1'b0;
    repeat (1 + ($urandom % 4)) @(negedge clk);
    fault_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({flt_a, flt_b, flt_c} == 3'b111, "R9", "flags set", {flt_a, flt_b, flt_c}, 3'b111);
    repeat (20) @(negedge clk);
    chk({flt_a, flt_b, flt_c} == 3'b111, "R9", "flags held", {flt_a, flt_b, flt_c}, 3'b111);

    // Clear while fault still active: fault wins, run restarts
    fault_n = 1'b0;
    repeat (4) @(negedge clk);
    frame_cnt = 0; clr_fault = 1'b1;
    @(negedge clk); clr_fault = 1'b0;
    chk(cfg_ready == 1'b0, "R10", "ready dropped", cfg_ready, 0);
    @(negedge clk);
    chk({flt_a, flt_b, flt_c} == 3'b111, "R10", "active fault beats clear", {flt_a, flt_b, flt_c}, 3'b111);
    fault_n = 1'b1;
    wait_ready();
    chk(frame_cnt == 5 && cfg_ready, "R10", "rerun frames", frame_cnt, 5);

    // Clean clear, then abort in mid-frame
    repeat (5) @(negedge clk);
    frame_cnt = 0; clr_fault = 1'b1;
    @(negedge clk); clr_fault = 1'b0;
    chk({flt_a, flt_b, flt_c} == 3'b000, "R10", "flags cleared", {flt_a, flt_b, flt_c}, 0);
    chk(cfg_ready == 1'b0, "R10", "ready low after clear", cfg_ready, 0);
    for (int k = 0; k < 200 && spi_cs_n; k++) @(negedge clk);
    repeat ((3 + ($urandom % 8)) * DIV) @(negedge clk);
    chk(spi_cs_n == 1'b0, "R10", "in frame before abort", spi_cs_n, 0);
    abort_pend = 1'b1; frame_cnt = 0; clr_fault = 1'b1;
    @(negedge clk); clr_fault = 1'b0;
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10", "abort raises cs", {spi_cs_n, spi_sck}, 2'b10);
    wait_ready();
    chk(frame_cnt == 5 && cfg_ready, "R10", "full run after abort", frame_cnt, 5);

    summary();
    $finish;
  end
endmodule